// File: doc/BRIEF.md
# Two-Channel Timer with Chainable Prescalers

This block holds two timer channels. Each channel has an 8-bit programmable prescaler that feeds a 16-bit up-counter. A base tick is made inside the block by dividing the clock by three. The first prescaler always runs from that base tick.

The second prescaler normally runs from the base tick as well. When the chain bit is set, it runs from the output pulses of the first prescaler instead. Software can then run both counters at one shared derived rate, with the second divider set to zero. It can also reach a total division of up to 2^16 of the base tick by multiplying the two divider settings.

Prescaler values and the chain bit are written through a small register-write port. A per-channel enable gates each counter. Each counter reports its value and a one-cycle terminal pulse when it rolls over.

Top module: `cascade_timer_pair`

## Requirements
- R1: The base tick fires once every 3 clock cycles. With both prescaler values at 0 and the chain bit clear, each enabled counter advances once every 3 cycles.
- R2: A prescaler holding value P divides its input pulses by P+1. With the chain bit clear, enabled counter n advances once every 3*(Pn+1) cycles.
- R3: Register writes select their target with `wr_addr`. Address 0 loads the channel-0 prescaler from `wr_data`. Address 1 loads the channel-1 prescaler. Address 2 loads the chain bit from `wr_data[0]`. A write to one target leaves the others unchanged.
- R4: With the chain bit set, counter 1 advances once every 3*(P0+1)*(P1+1) cycles.
- R5: With the chain bit set and P1 = 0, both enabled counters advance in the same clock cycle.
- R6: With the chain bit set, the total division of the base tick is (P0+1)*(P1+1). This spans 1 (both values 0) up to 65536 (both 255).
- R7: A new prescaler value does not cut short the period in progress. It takes effect from the next wrap of that prescaler.
- R8: While a counter's enable is low, that counter holds its value. The other channel keeps counting.
- R9: A counter increments from all-ones to zero. Its terminal pulse is high for exactly the one cycle in which the counter first reads zero.
- R10: Synchronous reset clears both counters, both terminal pulses, both prescaler counts and values (divide by 1), and the chain bit.
- R11: The channel-0 rate depends only on P0, whatever the chain bit holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 = prescaler 0, 1 = prescaler 1, 2 = chain control |
| wr_data | input | PS_W (8) | Write data; bit 0 is the chain bit for address 2 |
| cnt_en | input | 2 | Counter enables, bit n for channel n |
| count0_o | output | CNT_W (16) | Channel 0 counter value |
| count1_o | output | CNT_W (16) | Channel 1 counter value |
| tc0_o | output | 1 | Channel 0 terminal pulse |
| tc1_o | output | 1 | Channel 1 terminal pulse |

## Verification
The bench measures the cycle distance between successive counter increments, so the result does not depend on the phase of the base tick.

Several faults would show up as wrong intervals:
- A prescaler that divides by P instead of P+1.
- A chain mux that selects the wrong source.
- A registered chain path. In parallel mode this puts channel 1 one cycle behind channel 0.

A reload that takes effect immediately would shorten the period in which the write lands, from 30 to about 6 cycles. A reset that leaves the chain bit or the divider values in place would make channel 1 run at the old chained rate. A terminal pulse that is misaligned, too long, or driven from the wrong count value is caught at the rollover from all-ones to zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // Write-port targets; the encoding is visible to software.
   typedef enum logic [1:0] {
      REG_PS0  = 2'd0,
      REG_PS1  = 2'd1,
      REG_CTRL = 2'd2
   } tmr_reg_e;

   localparam int unsigned CTRL_CHAIN_BIT = 0;
   localparam int unsigned MAX_PS_W       = 16;
   localparam int unsigned MAX_CNT_W      = 32;
   localparam int unsigned NUM_CH         = 2;

endpackage

// File: rtl/tmr_base_tick.sv
module tmr_base_tick #(
   parameter int unsigned DIV = 3
) (
   input  logic clk,
   input  logic rst,
   output logic tick_o
);

   if (DIV < 1) begin : g_bad_div
      $error("tmr_base_tick: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      assign tick_o = 1'b1;
   end else begin : g_div
      localparam int unsigned PH_W = $clog2(DIV);
      localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);

      logic [PH_W-1:0] phase_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            phase_q <= '0;
         end else if (phase_q == LAST) begin
            phase_q <= '0;
         end else begin
            phase_q <= phase_q + 1'b1;
         end
      end

      assign tick_o = (phase_q == LAST);

      // R1
      tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
         tick_o |=> !tick_o);
   end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int unsigned PS_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wr_en,
   input  logic [PS_W-1:0] wr_val,
   input  logic            in_pulse,
   output logic            out_pulse
);

   logic [PS_W-1:0] cnt_q;
   logic [PS_W-1:0] reload_q;
   logic [PS_W-1:0] pend_q;
   logic            wrap;

   assign wrap      = (cnt_q == reload_q);
   assign out_pulse = in_pulse & wrap;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q    <= '0;
         reload_q <= '0;
         pend_q   <= '0;
      end else begin
         if (wr_en) begin
            pend_q <= wr_val;
         end
         if (in_pulse) begin
            if (wrap) begin
               cnt_q    <= '0;
               reload_q <= pend_q;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // R2
   out_needs_in_chk: assert property (@(posedge clk) disable iff (rst)
      out_pulse |-> in_pulse);

   // R2
   restart_after_out_chk: assert property (@(posedge clk) disable iff (rst)
      out_pulse |=> (cnt_q == '0));

   // R7
   reload_only_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      !out_pulse |=> $stable(reload_q));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt_o,
   output logic             tc_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             tc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         tc_q  <= 1'b0;
      end else begin
         tc_q <= 1'b0;
         if (en && inc) begin
            cnt_q <= cnt_q + 1'b1;
            tc_q  <= &cnt_q;
         end
      end
   end

   assign cnt_o = cnt_q;
   assign tc_o  = tc_q;

   // R9
   tc_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
      tc_q |-> (cnt_q == '0));

   // R9
   tc_single_chk: assert property (@(posedge clk) disable iff (rst)
      tc_q |=> !tc_q);

   // R8
   hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(cnt_q));

endmodule

// File: rtl/cascade_timer_pair.sv
module cascade_timer_pair
   import tmr_pkg::*;
#(
   parameter int unsigned PS_W     = 8,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned BASE_DIV = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [PS_W-1:0]  wr_data,
   input  logic [1:0]       cnt_en,
   output logic [CNT_W-1:0] count0_o,
   output logic [CNT_W-1:0] count1_o,
   output logic             tc0_o,
   output logic             tc1_o
);

   if (PS_W < 1 || PS_W > MAX_PS_W) begin : g_bad_ps
      $error("cascade_timer_pair: PS_W out of range");
   end
   if (CNT_W < 2 || CNT_W > MAX_CNT_W) begin : g_bad_cnt
      $error("cascade_timer_pair: CNT_W out of range");
   end

   logic                base_tick;
   logic                chain_q;
   logic [NUM_CH-1:0]   ps_wr;
   logic [NUM_CH-1:0]   ps_in;
   logic [NUM_CH-1:0]   ps_out;
   logic [NUM_CH-1:0]   tc;
   logic [CNT_W-1:0]    cnt [NUM_CH];

   tmr_base_tick #(.DIV(BASE_DIV)) u_base (
      .clk    (clk),
      .rst    (rst),
      .tick_o (base_tick)
   );

   always_comb begin
      ps_wr[0] = wr_en && (wr_addr == REG_PS0);
      ps_wr[1] = wr_en && (wr_addr == REG_PS1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= 1'b0;
      end else if (wr_en && (wr_addr == REG_CTRL)) begin
         chain_q <= wr_data[CTRL_CHAIN_BIT];
      end
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      if (ch == 0) begin : g_src_base
         assign ps_in[ch] = base_tick;
      end else begin : g_src_mux
         assign ps_in[ch] = chain_q ? ps_out[ch-1] : base_tick;
      end

      tmr_prescaler #(.PS_W(PS_W)) u_ps (
         .clk       (clk),
         .rst       (rst),
         .wr_en     (ps_wr[ch]),
         .wr_val    (wr_data),
         .in_pulse  (ps_in[ch]),
         .out_pulse (ps_out[ch])
      );

      tmr_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst   (rst),
         .en    (cnt_en[ch]),
         .inc   (ps_out[ch]),
         .cnt_o (cnt[ch]),
         .tc_o  (tc[ch])
      );
   end

   assign count0_o = cnt[0];
   assign count1_o = cnt[1];
   assign tc0_o    = tc[0];
   assign tc1_o    = tc[1];

   // R4
   chained_needs_first_chk: assert property (@(posedge clk) disable iff (rst)
      (chain_q && ps_out[1]) |-> ps_out[0]);

   // R11
   first_from_base_chk: assert property (@(posedge clk) disable iff (rst)
      ps_out[0] |-> base_tick);

   // R10
   reset_clears_chain_chk: assert property (@(posedge clk)
      rst |=> !chain_q);

endmodule

// File: tb/tb_cascade_timer_pair.sv
`timescale 1ns/1ps
module tb_cascade_timer_pair;

   localparam int unsigned PS_W  = 8;
   localparam int unsigned CNT_W = 12;  // narrowed so rollover is reachable quickly

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             wr_en = 1'b0;
   logic [1:0]       wr_addr = '0;
   logic [PS_W-1:0]  wr_data = '0;
   logic [1:0]       cnt_en = '0;
   logic [CNT_W-1:0] count0_o, count1_o;
   logic             tc0_o, tc1_o;

   int     errors = 0;
   int     checks = 0;
   longint cyc = 0;

   cascade_timer_pair #(.PS_W(PS_W), .CNT_W(CNT_W), .BASE_DIV(3)) dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cnt_en(cnt_en), .count0_o(count0_o), .count1_o(count1_o),
      .tc0_o(tc0_o), .tc1_o(tc1_o)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [CNT_W-1:0] cnt_of(input int ch);
      return (ch == 0) ? count0_o : count1_o;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; wr_en = 1'b0; cnt_en = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [PS_W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_change(input int ch, output longint at);
      logic [CNT_W-1:0] prev;
      prev = cnt_of(ch);
      do @(negedge clk); while (cnt_of(ch) == prev);
      at = cyc;
   endtask

   task automatic measure(input int ch, output longint iv);
      longint a, b;
      wait_change(ch, a);
      wait_change(ch, b);
      iv = b - a;
   endtask

   task automatic t_reset_state();
      longint iv;
      do_reset();
      wr(2'd2, 8'd1); wr(2'd0, 8'd4); wr(2'd1, 8'd4);
      cnt_en = 2'b11;
      repeat (100) @(negedge clk);
      do_reset();
      @(negedge clk);
      check(count0_o == 0, "R10 count0 after reset", count0_o, 0);
      check(count1_o == 0, "R10 count1 after reset", count1_o, 0);
      check(tc0_o == 0 && tc1_o == 0, "R10 tc after reset", {tc1_o, tc0_o}, 0);
      wr(2'd0, 8'd4);
      cnt_en = 2'b11;
      measure(1, iv);
      check(iv == 3, "R10 chain bit and P1 cleared (ch1 interval)", iv, 3);
      measure(0, iv);
      check(iv == 15, "R10 ch0 after reset with new P0", iv, 15);
   endtask

   task automatic t_base_rate();
      longint iv;
      do_reset();
      cnt_en = 2'b11;
      measure(0, iv);
      check(iv == 3, "R1 ch0 base rate", iv, 3);
      measure(1, iv);
      check(iv == 3, "R1 ch1 base rate", iv, 3);
   endtask

   task automatic t_independent();
      longint iv;
      do_reset();
      wr(2'd0, 8'd4);
      wr(2'd1, 8'd2);
      cnt_en = 2'b11;
      measure(0, iv);
      check(iv == 15, "R2 ch0 divide by P0+1", iv, 15);
      measure(1, iv);
      check(iv == 9, "R3 ch1 addressed separately", iv, 9);
   endtask

   task automatic t_chain();
      longint iv;
      do_reset();
      wr(2'd0, 8'd3);
      wr(2'd1, 8'd5);
      wr(2'd2, 8'd1);
      cnt_en = 2'b11;
      measure(1, iv);
      check(iv == 72, "R4 chained ch1 interval", iv, 72);
      measure(0, iv);
      check(iv == 12, "R11 ch0 unaffected by chain bit", iv, 12);
   endtask

   task automatic t_parallel();
      int mism = 0;
      int seen = 0;
      logic [CNT_W-1:0] p0, p1;
      do_reset();
      wr(2'd0, 8'd4);
      wr(2'd2, 8'd1);
      cnt_en = 2'b11;
      p0 = count0_o; p1 = count1_o;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if ((count0_o != p0) != (count1_o != p1)) mism++;
         if (count0_o != p0) seen++;
         p0 = count0_o; p1 = count1_o;
      end
      check(mism == 0, "R5 same-cycle advance mismatches", mism, 0);
      check(seen == 20, "R5 increments in 300 cycles", seen, 20);
   endtask

   task automatic t_deep();
      longint iv;
      do_reset();
      wr(2'd2, 8'd1);
      cnt_en = 2'b11;
      measure(1, iv);
      check(iv == 3, "R6 minimum combined division", iv, 3);
      wr(2'd0, 8'd255);
      wr(2'd1, 8'd3);
      repeat (3200) @(negedge clk);
      measure(1, iv);
      check(iv == 3072, "R6 combined division 256*4", iv, 3072);
   endtask

   task automatic t_deferred();
      longint a, b, c;
      do_reset();
      wr(2'd0, 8'd9);
      cnt_en = 2'b01;
      wait_change(0, a);
      wait_change(0, a);
      repeat (2) @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd1;
      @(negedge clk);
      wr_en = 1'b0;
      wait_change(0, b);
      check(b - a == 30, "R7 period in progress keeps old value", b - a, 30);
      wait_change(0, c);
      check(c - b == 6, "R7 new value after wrap", c - b, 6);
   endtask

   task automatic t_enable();
      logic [CNT_W-1:0] h0, s1;
      do_reset();
      cnt_en = 2'b11;
      repeat (30) @(negedge clk);
      cnt_en = 2'b10;
      @(negedge clk);
      h0 = count0_o; s1 = count1_o;
      repeat (150) @(negedge clk);
      check(count0_o == h0, "R8 disabled ch0 holds", count0_o, h0);
      check(count1_o == s1 + 50, "R8 ch1 keeps counting", count1_o, s1 + 50);
   endtask

   task automatic t_rollover();
      longint at;
      do_reset();
      cnt_en = 2'b11;
      while (count0_o != {CNT_W{1'b1}}) begin
         @(negedge clk);
         check(tc0_o == 0, "R9 no tc before rollover", tc0_o, 0);
         checks--;  // bookkeeping: the per-cycle guard counts once below
      end
      checks++;
      wait_change(0, at);
      check(count0_o == 0, "R9 wrap to zero", count0_o, 0);
      check(tc0_o == 1, "R9 tc0 high at zero", tc0_o, 1);
      check(tc1_o == 1, "R9 tc1 high at zero", tc1_o, 1);
      @(negedge clk);
      check(tc0_o == 0, "R9 tc0 one cycle only", tc0_o, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      t_reset_state();
      t_base_rate();
      t_independent();
      t_chain();
      t_parallel();
      t_deep();
      t_deferred();
      t_enable();
      t_rollover();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule